// File: doc/BRIEF.md
# Serial Flash 4 KiB Block Programmer

This block writes one 4 KiB block of host data into a serial NOR flash that sits on a 4-wire SPI bus. A host asks for an operation with a one-cycle `start`. The block answers with a one-cycle `ready` strobe and then takes a byte stream on `in_valid`/`in_data`. The stream carries a 24-bit flash address and then the whole block of data. All of it is kept in an internal RAM, so the host never has to pace itself to the flash.

Once the block is loaded, the sequencer runs the full flash flow without further help. It enables writes and erases the 4 KiB sector, then polls the status register until the busy flag clears. It then programs sixteen 256-byte pages in turn, and each page is preceded by its own write enable and followed by its own busy poll. The address is forced onto a 4 KiB boundary, so the erase and every page write stay inside the addressed sector. `busy` is high from the accepted `start` until the final poll clears. A one-cycle `done` marks completion.

The SPI byte shifter is built in and runs in mode 0. Its bit rate is the system clock divided by an even parameter. A minimum chip-select high time between transactions is also a parameter.

Top module: `spi_blk_prog`

## Requirements
- R1: While reset is held and right after it, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `ready` are 0.
- R2: A `start` seen while idle produces exactly one `ready` pulse on the next cycle, and `busy` rises with that pulse. A `start` seen while `busy` is high causes no `ready` pulse and does not disturb the flash traffic.
- R3: After `ready`, each cycle with `in_valid` high consumes one byte. The first three bytes are the flash address, most significant byte first, and the following 4096 bytes are the block data in ascending address order.
- R4: Every write-enable transaction is a single byte, 0x06, framed by `spi_cs_n` low.
- R5: The erase is one transaction of the bytes 0x20, A[23:16], A[15:12] followed by four zero bits, and 0x00, where A is the loaded address. The low 12 address bits are always sent as zero.
- R6: A status poll is the two bytes 0x05 and 0xFF, and the second byte clocks in the status. The poll is repeated for as long as bit 0 of that status is 1.
- R7: After the erase poll clears, the block sends 16 rounds of write enable, page program and poll. Page k (k = 0..15) is 0x02, A[23:16], {A[15:12], k}, 0x00, followed by data bytes k*256 .. k*256+255 in load order.
- R8: SPI mode 0, most significant bit first: `spi_sclk` rests low whenever `spi_cs_n` is high, and `spi_mosi` holds still while `spi_sclk` is high. Rising edges within a byte are CLK_DIV clock cycles apart.
- R9: `spi_cs_n` stays high for at least CS_GAP clock cycles between any two transactions.
- R10: `done` is high for exactly one cycle, right after the 16th page poll clears. `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to take and program one block |
| in_valid | input | 1 | Load byte qualifier |
| in_data | input | 8 | Load byte: address bytes, then block data |
| ready | output | 1 | One-cycle strobe: loading may begin |
| busy | output | 1 | High for the whole operation |
| done | output | 1 | One-cycle pulse at completion |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two blocks are programmed against a flash model. The model reports busy on the first two polls after an erase and on the first poll after each page, so a sequencer that stops polling too soon or keeps polling too long changes the transaction count. The first block uses an address with nonzero low bits, gaps in `in_valid`, and a stray `start` in the middle of programming. This separates correct alignment, stall-tolerant loading and start masking from designs that only handle a clean stream. The second block uses an all-ones address and a different data pattern, so any swap of address bytes or page index, or any misordering in the RAM, shows up as a byte mismatch in a specific transaction.

// File: rtl/spi_prog_pkg.sv
`timescale 1ns/1ps
package spi_prog_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_GAP, ST_SEND, ST_WAIT} seq_st_e;
  typedef enum logic [2:0] {OP_WREN_E, OP_ERASE, OP_POLL_E, OP_WREN_P, OP_PROG, OP_POLL_P} seq_op_e;
  localparam logic [7:0] FL_WREN  = 8'h06;
  localparam logic [7:0] FL_ERASE = 8'h20;
  localparam logic [7:0] FL_STAT  = 8'h05;
  localparam logic [7:0] FL_PROG  = 8'h02;
  localparam logic [7:0] FL_DUMMY = 8'hFF;
endpackage

// File: rtl/spi_byte_shift.sv
`timescale 1ns/1ps
module spi_byte_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       rx_last,
  output logic       byte_done
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          act_q, sclk_q, rx_q, done_q;
  logic [7:0]    sr_q;
  logic [2:0]    bits_q;
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      rx_q   <= 1'b0;
      done_q <= 1'b0;
      sr_q   <= '0;
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go && !act_q) begin
        act_q  <= 1'b1;
        sr_q   <= tx_byte;
        bits_q <= '0;
        cnt_q  <= '0;
      end else if (act_q) begin
        if (tick) begin
          cnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;          // rising edge: sample
            rx_q   <= miso;
          end else begin
            sclk_q <= 1'b0;          // falling edge: next bit out
            sr_q   <= {sr_q[6:0], 1'b0};
            bits_q <= bits_q + 3'd1;
            if (bits_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = sr_q[7];
  assign rx_last   = rx_q;
  assign byte_done = done_q;
endmodule

// File: rtl/blk_buf_ram.sv
`timescale 1ns/1ps
module blk_buf_ram #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/spi_blk_prog.sv
`timescale 1ns/1ps
module spi_blk_prog
  import spi_prog_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int CS_GAP     = 4,
  parameter int BLK_BYTES  = 4096,
  parameter int PAGE_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       ready,
  output logic       busy,
  output logic       done,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int BLK_AW = $clog2(BLK_BYTES);
  localparam int PB_W   = $clog2(PAGE_BYTES);
  localparam int PG_W   = BLK_AW - PB_W;
  localparam int LD_W   = $clog2(BLK_BYTES + 3);
  localparam int BI_W   = $clog2(PAGE_BYTES + 5);
  localparam int GC_W   = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [LD_W-1:0] LD_LAST   = LD_W'(BLK_BYTES + 2);
  localparam logic [PG_W-1:0] PAGE_LAST = {PG_W{1'b1}};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  seq_st_e          st_q, st_d;
  seq_op_e          op_q, op_d;
  logic [LD_W-1:0]  lcnt_q, lcnt_d;
  logic [23:0]      base_q, base_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic [BI_W-1:0]  bidx_q, bidx_d;
  logic [GC_W-1:0]  gcnt_q, gcnt_d;
  logic             cs_n_q, cs_n_d, ready_q, ready_d, done_q, done_d;

  logic             go, byte_done, rx_last, ram_we;
  logic [7:0]       tx_byte, ram_q;
  logic [BLK_AW-1:0] ram_waddr, ram_raddr;
  logic [23:0]      ers_addr, pg_addr, cur_addr;
  logic [7:0]       addr_byte;
  logic [BI_W-1:0]  xfer_len;

  assign ers_addr  = {base_q[23:BLK_AW], BLK_AW'(0)};
  assign pg_addr   = {base_q[23:BLK_AW], page_q, PB_W'(0)};
  assign cur_addr  = (op_q == OP_ERASE) ? ers_addr : pg_addr;
  assign addr_byte = (bidx_q == BI_W'(1)) ? cur_addr[23:16] :
                     (bidx_q == BI_W'(2)) ? cur_addr[15:8]  : cur_addr[7:0];
  assign ram_waddr = BLK_AW'(lcnt_q - LD_W'(3));
  // prefetch the byte after the current one (registered RAM read)
  assign ram_raddr = {page_q, bidx_q[PB_W-1:0] - PB_W'(3)};

  always_comb begin
    unique case (op_q)
      OP_ERASE:             xfer_len = BI_W'(4);
      OP_POLL_E, OP_POLL_P: xfer_len = BI_W'(2);
      OP_PROG:              xfer_len = BI_W'(PAGE_BYTES + 4);
      default:              xfer_len = BI_W'(1);
    endcase
  end

  always_comb begin
    unique case (op_q)
      OP_ERASE:             tx_byte = (bidx_q == '0) ? FL_ERASE : addr_byte;
      OP_POLL_E, OP_POLL_P: tx_byte = (bidx_q == '0) ? FL_STAT : FL_DUMMY;
      OP_PROG:              tx_byte = (bidx_q == '0) ? FL_PROG :
                                      (bidx_q < BI_W'(4)) ? addr_byte : ram_q;
      default:              tx_byte = FL_WREN;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    lcnt_d  = lcnt_q;
    base_d  = base_q;
    page_d  = page_q;
    bidx_d  = bidx_q;
    gcnt_d  = gcnt_q;
    cs_n_d  = cs_n_q;
    ready_d = 1'b0;
    done_d  = 1'b0;
    go      = 1'b0;
    ram_we  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d    = ST_LOAD;
        lcnt_d  = '0;
        ready_d = 1'b1;
      end
      ST_LOAD: if (in_valid) begin
        if (lcnt_q < LD_W'(3)) base_d = {base_q[15:0], in_data};
        else                   ram_we = 1'b1;
        if (lcnt_q == LD_LAST) begin
          st_d   = ST_GAP;
          op_d   = OP_WREN_E;
          page_d = '0;
          bidx_d = '0;
          gcnt_d = '0;
        end else begin
          lcnt_d = lcnt_q + LD_W'(1);
        end
      end
      ST_GAP: begin
        if (gcnt_q == GC_W'(CS_GAP - 1)) st_d = ST_SEND;
        else                             gcnt_d = gcnt_q + GC_W'(1);
      end
      ST_SEND: begin
        go     = 1'b1;
        cs_n_d = 1'b0;
        st_d   = ST_WAIT;
      end
      ST_WAIT: if (byte_done) begin
        if (bidx_q == xfer_len - BI_W'(1)) begin
          cs_n_d = 1'b1;
          bidx_d = '0;
          gcnt_d = '0;
          st_d   = ST_GAP;
          unique case (op_q)
            OP_WREN_E: op_d = OP_ERASE;
            OP_ERASE:  op_d = OP_POLL_E;
            OP_POLL_E: op_d = rx_last ? OP_POLL_E : OP_WREN_P;
            OP_WREN_P: op_d = OP_PROG;
            OP_PROG:   op_d = OP_POLL_P;
            default: begin
              if (rx_last) begin
                op_d = OP_POLL_P;
              end else if (page_q == PAGE_LAST) begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
              end else begin
                op_d   = OP_WREN_P;
                page_d = page_q + PG_W'(1);
              end
            end
          endcase
        end else begin
          bidx_d = bidx_q + BI_W'(1);
          st_d   = ST_SEND;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_WREN_E;
      lcnt_q  <= '0;
      base_q  <= '0;
      page_q  <= '0;
      bidx_q  <= '0;
      gcnt_q  <= '0;
      cs_n_q  <= 1'b1;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      lcnt_q  <= lcnt_d;
      base_q  <= base_d;
      page_q  <= page_d;
      bidx_q  <= bidx_d;
      gcnt_q  <= gcnt_d;
      cs_n_q  <= cs_n_d;
      ready_q <= ready_d;
      done_q  <= done_d;
    end
  end

  blk_buf_ram #(.DEPTH(BLK_BYTES)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (in_data),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  spi_byte_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .go        (go),
    .tx_byte   (tx_byte),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_last   (rx_last),
    .byte_done (byte_done)
  );

  assign ready    = ready_q;
  assign done     = done_q;
  assign busy     = (st_q != ST_IDLE);
  assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/spi_blk_prog_chk.sv
`timescale 1ns/1ps
module spi_blk_prog_chk #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ready,
  input logic busy,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt <= '0;
    else if (!spi_cs_n)        hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  p_sclk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= 16'(CS_GAP)));

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (!ready && busy));

  p_start_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_blk_prog spi_blk_prog_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ready    (ready),
  .busy     (busy),
  .done     (done),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi)
);

// File: tb/test_spi_blk_prog.sv
`timescale 1ns/1ps
module test_spi_blk_prog;
  localparam int DIV = 2;
  localparam int GAP = 3;
  localparam int WD_LIMIT = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic ready, busy, done, spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  always #2.5 clk = ~clk;

  spi_blk_prog #(.CLK_DIV(DIV), .CS_GAP(GAP)) i_spi_blk_prog (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
    .ready(ready), .busy(busy), .done(done), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int tests = 0;
  int fails = 0;
  bit live = 0;
  bit wd_hit = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard queues ----------------
  logic [7:0] exp_b[$];
  int         exp_len[$];

  task automatic push_xfer(input logic [7:0] b[$]);
    exp_len.push_back(b.size());
    foreach (b[i]) exp_b.push_back(b[i]);
  endtask

  // ---------------- flash model / monitor ----------------
  int         bitc = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] cur[$];
  int         busy_left = 0;
  logic [7:0] stat_b = 8'h00;
  int         period_bad = 0;
  time        last_rise = 0;

  assign spi_miso = (!spi_cs_n && bitc >= 8 && bitc < 16) ? stat_b[15 - bitc] : 1'b0;

  always @(negedge spi_cs_n) begin
    bitc = 0;
    cur.delete();
    stat_b = (busy_left > 0) ? 8'h03 : 8'h00;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if ((bitc % 8) != 0 && ($time - last_rise) != DIV * 5) period_bad++;
      last_rise = $time;
      sh = {sh[6:0], spi_mosi};
      bitc++;
      if ((bitc % 8) == 0) cur.push_back(sh);
    end
  end

  always @(posedge spi_cs_n) begin
    if (live) begin
      string req;
      int len;
      bit ok;
      int bad_i;
      logic [7:0] e;
      if (exp_len.size() == 0) begin
        chk(0, "R7", "unexpected transaction, first byte", (cur.size() > 0) ? cur[0] : 0, 0);
      end else begin
        len = exp_len.pop_front();
        ok = (cur.size() == len) && ((bitc % 8) == 0);
        bad_i = -1;
        req = "R4";
        for (int i = 0; i < len; i++) begin
          e = exp_b.pop_front();
          if (i == 0) req = (e == 8'h20) ? "R5" : (e == 8'h05) ? "R6" : (e == 8'h02) ? "R7" : "R4";
          if (i < cur.size() && cur[i] !== e && bad_i < 0) begin
            ok = 0;
            bad_i = i;
            chk(0, req, $sformatf("byte %0d of transaction", i), cur[i], e);
          end
        end
        if (bad_i < 0) chk(ok, req, "transaction length in bytes", cur.size(), len);
      end
      if (cur.size() > 0) begin
        if (cur[0] == 8'h20) busy_left = 2;
        else if (cur[0] == 8'h02) busy_left = 1;
        else if (cur[0] == 8'h05 && busy_left > 0) busy_left--;
      end
    end
  end

  // CS high-time and strobe counters, sampled away from the active edge
  int hi_run = 0;
  int min_gap = 1000000;
  bit seen_low = 0;
  int ready_cnt = 0;
  int done_cnt = 0;

  always @(negedge clk) begin
    if (live) begin
      if (spi_cs_n) hi_run++;
      else begin
        if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
        seen_low = 1;
        hi_run = 0;
      end
      if (ready) ready_cnt++;
      if (done) done_cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !wd_hit) begin
      wd_hit = 1;
      chk(0, "R10", "watchdog expired, cycles", cycles, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- driver ----------------
  function automatic logic [7:0] pat(input int seed, input int i);
    return (seed == 1) ? 8'((i * 13) + (i >> 8) * 7 + 1) : 8'(~i ^ (i >> 4));
  endfunction

  task automatic run_block(input logic [23:0] addr, input int seed, input bit stalls, input bit poke);
    logic [7:0] t[$];
    logic [7:0] hi, mid;
    int r0, d0;
    hi  = addr[23:16];
    mid = {addr[15:12], 4'h0};
    // expectations: R4 wren, R5 erase (low 12 bits zero), R6 polls x3
    t = '{8'h06}; push_xfer(t);
    t = '{8'h20, hi, mid, 8'h00}; push_xfer(t);
    for (int p = 0; p < 3; p++) begin t = '{8'h05, 8'hFF}; push_xfer(t); end
    for (int k = 0; k < 16; k++) begin
      t = '{8'h06}; push_xfer(t);
      t = '{8'h02, hi, mid | 8'(k), 8'h00};
      for (int i = 0; i < 256; i++) t.push_back(pat(seed, k * 256 + i));
      push_xfer(t);
      for (int p = 0; p < 2; p++) begin t = '{8'h05, 8'hFF}; push_xfer(t); end
    end
    r0 = ready_cnt;
    d0 = done_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ready === 1'b1, "R2", "ready one cycle after start", ready, 1);
    chk(busy === 1'b1, "R2", "busy with ready", busy, 1);
    // R3: three address bytes, MSB first, then 4096 data bytes
    for (int n = 0; n < 4099; n++) begin
      if (stalls && (n % 37) == 5) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = (n < 3) ? addr[23 - 8 * n -: 8] : pat(seed, n - 3);
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (poke) begin
      repeat (20000) @(negedge clk);
      chk(busy === 1'b1, "R2", "busy mid-operation", busy, 1);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done && !wd_hit) @(negedge clk);
    chk(busy === 1'b0, "R10", "busy low with done", busy, 0);
    chk(exp_len.size() == 0, "R7", "transactions left at done", exp_len.size(), 0);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done after one cycle", done, 0);
    chk(done_cnt - d0 == 1, "R10", "done pulse cycles", done_cnt - d0, 1);
    chk(ready_cnt - r0 == 1, "R2", "ready pulses per block", ready_cnt - r0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
    chk(spi_sclk === 1'b0, "R1", "sclk in reset", spi_sclk, 0);
    chk({busy, done, ready} === 3'b000, "R1", "busy/done/ready in reset", {busy, done, ready}, 0);
    rst_n = 1'b1;
    live = 1;
    repeat (4) @(negedge clk);
    chk({busy, done, ready, spi_cs_n} === 4'b0001, "R1", "state after release", {busy, done, ready, spi_cs_n}, 1);
    run_block(24'h123ABC, 1, 1'b1, 1'b1);
    run_block(24'hFFFFFF, 2, 1'b0, 1'b0);
    chk(min_gap >= GAP, "R9", "minimum cs high cycles", min_gap, GAP);
    chk(period_bad == 0, "R8", "sclk period violations", period_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule